// File: doc/BRIEF.md
# Eight-Level Prioritized Vectored Interrupt Controller

This block gathers eight active-high, level-sensitive interrupt request lines, masks them, ranks them by fixed priority and raises a single interrupt output towards a processor. Software configures it through two byte-wide register offsets, and a small command decoder tells the command words apart by the offset and by a few data bits. A short initialization sequence sets the upper bits of the vector byte and picks the nesting mode. After that, masks, end-of-interrupt commands and the selection of the status read are accepted at any time.

The processor answers the interrupt with two acknowledge strobes. The first strobe commits the winning level and marks it in service. The second strobe returns a vector byte, made of the programmed base and the level number. A level stays in service until software names it in a specific end-of-interrupt command. While it is in service, it holds off requests of equal and lower priority.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A write to offset 0 (addr_i=0) with data bit 4 set restarts initialization. It clears the mask and in-service registers, cancels a pending acknowledge, and selects the request register for offset-0 reads.
- R2: After that restart, the next two writes to offset 2 (addr_i=1) are taken in order as the base word and then the mode word. int_o stays low until the mode word has been written.
- R3: The vector byte carries base-word bits 7:3 in bits 7:3 and the acknowledged level number (0 to 7) in bits 2:0.
- R4: The first ack_i strobe commits the highest eligible level and sets its in-service bit, and no vector is returned. The second strobe makes vec_valid_o high for exactly one cycle, the cycle after that strobe, with the vector on vec_o.
- R5: Once initialized, a write to offset 2 loads the mask register. Bit i set to 1 blocks request i only, and a read of offset 2 returns the mask register.
- R6: A write to offset 0 with bits 4:3 = 00 clears the in-service bit of the level given in bits 2:0. Bits 7:5 have no effect.
- R7: In the default nesting mode, a request raises int_o only if its level is numerically lower than every in-service level. A strictly higher-priority request preempts.
- R8: A write to offset 0 with bits 4:3 = 01 selects what offset-0 reads return: bit 0 = 0 gives the request register and bit 0 = 1 gives the in-service register. The choice persists until it is changed.
- R9: Mode-word bit 4 = 1 selects special nesting, in which a request at the same level as the in-service level may interrupt again. The other mode-word bits have no effect.
- R10: When several unmasked requests are pending, the lowest-numbered level wins.
- R11: If no request is eligible at the first ack_i strobe, no in-service bit is set, and the second strobe returns the vector with level field 7.
- R12: During initialization, offset-0 writes with bit 4 clear are ignored.
- R13: irq_i is sampled through one register, so int_o responds in the cycle after the line changes at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Offset select: 0 for offset 0, 1 for offset 2 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, zero when not reading |
| irq_i | input | 8 | Level-sensitive requests, bit 0 highest priority |
| ack_i | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector byte valid |
| vec_o | output | 8 | Vector byte |

## Verification
The bench builds the block with its defaults: eight levels and an eight-bit data path. This gives a five-bit base field and a three-bit level field, so the vector byte exactly fills the data width. With these values every priority relation can be reached, including the spurious code of level 7 and nesting against both higher and lower levels. Two base values are programmed across two initializations, so the vector checks cover a restart that happens while a level is still in service.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    CFG_IDLE,
    CFG_WAIT_BASE,
    CFG_WAIT_MODE,
    CFG_READY
  } cfg_state_e;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int DATA_W  = 8,
  localparam int LVL_W  = $clog2(NUM_LVL),
  localparam int BASE_W = DATA_W - LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_LVL-1:0] mask_o,
  output logic [BASE_W-1:0]  base_o,
  output logic               sfnm_o,
  output logic               rd_isr_o,
  output logic               ready_o,
  output logic               init_o,
  output logic               eoi_o,
  output logic [LVL_W-1:0]   eoi_lvl_o
);
  cfg_state_e state_q;
  logic wr_lo, wr_hi, sel_ocw3;

  assign wr_lo     = wr_en_i & ~addr_i;
  assign wr_hi     = wr_en_i & addr_i;
  assign ready_o   = (state_q == CFG_READY);
  assign init_o    = wr_lo & wdata_i[4];
  assign eoi_o     = wr_lo & ready_o & (wdata_i[4:3] == 2'b00);
  assign sel_ocw3  = wr_lo & ready_o & (wdata_i[4:3] == 2'b01);
  assign eoi_lvl_o = wdata_i[LVL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CFG_IDLE;
      mask_o   <= '0;
      base_o   <= '0;
      sfnm_o   <= 1'b0;
      rd_isr_o <= 1'b0;
    end else if (init_o) begin
      state_q  <= CFG_WAIT_BASE;
      mask_o   <= '0;
      rd_isr_o <= 1'b0;
    end else begin
      unique case (state_q)
        CFG_WAIT_BASE: if (wr_hi) begin
          base_o  <= wdata_i[DATA_W-1:LVL_W];
          state_q <= CFG_WAIT_MODE;
        end
        CFG_WAIT_MODE: if (wr_hi) begin
          sfnm_o  <= wdata_i[4];
          state_q <= CFG_READY;
        end
        CFG_READY: begin
          if (wr_hi)    mask_o   <= wdata_i[NUM_LVL-1:0];
          if (sel_ocw3) rd_isr_o <= wdata_i[0];
        end
        default: ;
      endcase
    end
  end

  assert_restart_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> (mask_o == '0) && !ready_o && !rd_isr_o);

  assert_ready_after_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(wr_hi) && ($past(state_q) == CFG_WAIT_MODE));

  assert_init_ignores_lo_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && wr_lo && !wdata_i[4]) |=> $stable(rd_isr_o) && $stable(mask_o));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [NUM_LVL-1:0] isr_i,
  input  logic               sfnm_i,
  output logic               req_any_o,
  output logic [LVL_W-1:0]   req_lvl_o,
  output logic               grant_o
);
  logic             isr_any;
  logic [LVL_W-1:0] isr_lvl;

  // scan downward so the lowest index is left standing
  always_comb begin
    req_any_o = 1'b0;
    req_lvl_o = '0;
    isr_any   = 1'b0;
    isr_lvl   = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        req_any_o = 1'b1;
        req_lvl_o = LVL_W'(i);
      end
      if (isr_i[i]) begin
        isr_any = 1'b1;
        isr_lvl = LVL_W'(i);
      end
    end
  end

  assign grant_o = req_any_o &&
                   (!isr_any || (req_lvl_o < isr_lvl) || (sfnm_i && req_lvl_o == isr_lvl));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int NUM_LVL = 8,
  parameter int DATA_W  = 8,
  localparam int LVL_W  = $clog2(NUM_LVL),
  localparam int BASE_W = DATA_W - LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic               addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_LVL-1:0] irq_i,
  input  logic               ack_i,
  output logic               int_o,
  output logic               vec_valid_o,
  output logic [DATA_W-1:0]  vec_o
);
  logic [NUM_LVL-1:0] mask, irr_q, isr_q, isr_d, pend;
  logic [BASE_W-1:0]  base;
  logic               sfnm, rd_isr, ready, init, eoi;
  logic [LVL_W-1:0]   eoi_lvl, req_lvl, ack_lvl_q;
  logic               req_any, grant, ack_phase_q, commit;

  irqc_cfg #(.NUM_LVL(NUM_LVL), .DATA_W(DATA_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (sel_i & wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .mask_o    (mask),
    .base_o    (base),
    .sfnm_o    (sfnm),
    .rd_isr_o  (rd_isr),
    .ready_o   (ready),
    .init_o    (init),
    .eoi_o     (eoi),
    .eoi_lvl_o (eoi_lvl)
  );

  assign pend = irr_q & ~mask;

  irqc_prio #(.NUM_LVL(NUM_LVL)) i_prio (
    .req_i     (pend),
    .isr_i     (isr_q),
    .sfnm_i    (sfnm),
    .req_any_o (req_any),
    .req_lvl_o (req_lvl),
    .grant_o   (grant)
  );

  assign int_o  = ready & grant & ~ack_phase_q;
  assign commit = ack_i & ~ack_phase_q & ready & grant;

  // clear after set: an EOI in the commit cycle wins
  always_comb begin
    isr_d = isr_q;
    if (commit) isr_d[req_lvl] = 1'b1;
    if (eoi)    isr_d[eoi_lvl] = 1'b0;
    if (init)   isr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q       <= '0;
      isr_q       <= '0;
      ack_phase_q <= 1'b0;
      ack_lvl_q   <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      irr_q       <= irq_i;
      isr_q       <= isr_d;
      vec_valid_o <= 1'b0;
      if (init) begin
        ack_phase_q <= 1'b0;
      end else if (ack_i) begin
        if (!ack_phase_q) begin
          ack_phase_q <= 1'b1;
          ack_lvl_q   <= commit ? req_lvl : '1;
        end else begin
          ack_phase_q <= 1'b0;
          vec_valid_o <= 1'b1;
          vec_o       <= {base, ack_lvl_q};
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i)
      rdata_o = addr_i ? DATA_W'(mask) : DATA_W'(rd_isr ? isr_q : irr_q);
  end

  assert_int_needs_unmasked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr_q & ~mask));

  assert_vec_after_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i));

  assert_vec_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> vec_o[DATA_W-1:LVL_W] == $past(base));

  assert_commit_sets_isr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_phase_q && int_o && !eoi && !init) |=> isr_q[$past(req_lvl)]);

  assert_eoi_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !init) |=> !isr_q[$past(eoi_lvl)]);

  assert_no_req_no_commit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_phase_q && !req_any && !eoi && !init) |=> isr_q == $past(isr_q));
endmodule

// File: tb/test_irq_vec_ctrl.sv
`timescale 1ns/1ps
module test_irq_vec_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq = '0;
  logic [7:0] rdata, vec;
  logic       intr, vec_valid;
  int         errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .ack_i(ack), .int_o(intr),
    .vec_valid_o(vec_valid), .vec_o(vec)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic reg_rd(input logic a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #1 d = rdata;
    sel = 0; rd = 0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  task automatic ack_pair(output logic [7:0] v, output logic valid1, output logic valid2);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0; valid1 = vec_valid;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0; valid2 = vec_valid; v = vec;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R2 int low after reset", {7'b0, intr}, 8'h00);
    check("R4 no vector after reset", {7'b0, vec_valid}, 8'h00);
    set_irq(8'h01);
    check("R2 int low before init", {7'b0, intr}, 8'h00);
    reg_rd(1'b1, d);
    check("R5 mask reset", d, 8'h00);
  endtask

  task automatic t_init;
    logic [7:0] d;
    reg_wr(1'b0, 8'h13);
    check("R2 int low after restart", {7'b0, intr}, 8'h00);
    reg_wr(1'b1, 8'h40);
    check("R2 int low after base word", {7'b0, intr}, 8'h00);
    reg_wr(1'b0, 8'h0B);
    reg_wr(1'b1, 8'h01);
    check("R2 int high after mode word", {7'b0, intr}, 8'h01);
    reg_rd(1'b0, d);
    check("R12 R1 offset0 reads request reg", d, 8'h01);
  endtask

  task automatic t_vector;
    logic [7:0] v, d; logic v1, v2;
    ack_pair(v, v1, v2);
    check("R4 no vector on first ack", {7'b0, v1}, 8'h00);
    check("R4 vector on second ack", {7'b0, v2}, 8'h01);
    check("R3 vector byte level 0", v, 8'h40);
    check("R7 level 0 in service blocks itself", {7'b0, intr}, 8'h00);
    reg_wr(1'b0, 8'h0B);
    reg_rd(1'b0, d);
    check("R8 in-service read", d, 8'h01);
    reg_wr(1'b0, 8'hE0);
    reg_rd(1'b0, d);
    check("R6 R8 EOI clears, select persists", d, 8'h00);
    check("R6 request re-raises int", {7'b0, intr}, 8'h01);
    set_irq(8'h00);
    check("R13 int follows dropped line", {7'b0, intr}, 8'h00);
    reg_wr(1'b0, 8'h0A);
  endtask

  task automatic t_mask;
    logic [7:0] v, d; logic v1, v2;
    reg_wr(1'b1, 8'h04);
    set_irq(8'h0C);
    reg_rd(1'b1, d);
    check("R5 mask readback", d, 8'h04);
    ack_pair(v, v1, v2);
    check("R5 masked level skipped", v, 8'h43);
    reg_wr(1'b0, 8'h03);
    reg_wr(1'b1, 8'hFF);
    check("R5 all masked", {7'b0, intr}, 8'h00);
    reg_wr(1'b1, 8'h00);
    check("R5 unmasked raises int", {7'b0, intr}, 8'h01);
    ack_pair(v, v1, v2);
    check("R10 lowest level wins", v, 8'h42);
    reg_wr(1'b0, 8'h02);
    set_irq(8'h00);
  endtask

  task automatic t_nest;
    logic [7:0] v, d; logic v1, v2;
    set_irq(8'h10);
    ack_pair(v, v1, v2);
    check("R3 vector byte level 4", v, 8'h44);
    check("R7 equal level blocked", {7'b0, intr}, 8'h00);
    set_irq(8'h30);
    check("R7 lower level blocked", {7'b0, intr}, 8'h00);
    set_irq(8'h32);
    check("R7 higher level preempts", {7'b0, intr}, 8'h01);
    ack_pair(v, v1, v2);
    check("R7 preempting vector", v, 8'h41);
    reg_wr(1'b0, 8'h0B);
    reg_rd(1'b0, d);
    check("R7 nested in-service", d, 8'h12);
    reg_wr(1'b0, 8'h01);
    reg_wr(1'b0, 8'h04);
    reg_rd(1'b0, d);
    check("R6 both cleared", d, 8'h00);
    reg_wr(1'b0, 8'h0A);
    set_irq(8'h00);
  endtask

  task automatic t_sfnm;
    logic [7:0] v, d; logic v1, v2;
    set_irq(8'h10);
    ack_pair(v, v1, v2);
    reg_wr(1'b1, 8'hFF);
    reg_wr(1'b0, 8'h10);
    reg_rd(1'b1, d);
    check("R1 restart clears mask", d, 8'h00);
    reg_wr(1'b1, 8'h80);
    reg_wr(1'b1, 8'h11);
    reg_wr(1'b0, 8'h0B);
    reg_rd(1'b0, d);
    check("R1 restart clears in-service", d, 8'h00);
    check("R9 int high after reinit", {7'b0, intr}, 8'h01);
    ack_pair(v, v1, v2);
    check("R3 new base vector", v, 8'h84);
    check("R9 equal level re-interrupts", {7'b0, intr}, 8'h01);
    ack_pair(v, v1, v2);
    check("R9 second nested vector", v, 8'h84);
    reg_wr(1'b0, 8'h04);
    set_irq(8'h00);
    check("R9 idle after EOI and drop", {7'b0, intr}, 8'h00);
  endtask

  task automatic t_spurious;
    logic [7:0] v, d; logic v1, v2;
    set_irq(8'h40);
    check("R13 level 6 raises int", {7'b0, intr}, 8'h01);
    set_irq(8'h00);
    ack_pair(v, v1, v2);
    check("R11 vector after drop", {7'b0, v2}, 8'h01);
    check("R11 level field 7", v, 8'h87);
    reg_rd(1'b0, d);
    check("R11 no in-service set", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init();
    t_vector();
    t_mask();
    t_nest();
    t_sfnm();
    t_spurious();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule